// File: doc/BRIEF.md
# Cycle-Stealing Memory Port Multiplexer

This block shares one memory port among four requesters: a processor and three external channels. Each requester drives a request, an address, write data and a read/write select. It gets back an acknowledge and read data. Only one full memory cycle runs at a time. Channels steal cycles from the processor. The processor sees a stall only while its own request is waiting. A channel may front several external controllers, which merge into one requester before they reach this block.

The state machine has three states.
- ST_IDLE: arbitration takes place here and nowhere else. The transition IDLE to CYCLE is taken on any pending request. At that step the winner's address, data and direction are latched.
- ST_CYCLE: the memory request is held. The transition CYCLE to RETIRE is taken when the memory acknowledges. Read data is captured for the owner on that same transition.
- ST_RETIRE: the owner alone receives a one-clock acknowledge. The transition RETIRE to IDLE is unconditional.

A requester must hold its request until it sees its acknowledge. It must drop the request before the next arbitration.

Top module: `cyc_steal_mux`

## Requirements
- R1: While reset is held and after its release with no request pending: mem_req is low, every acknowledge is low, cpu_stall is low, and every read-data output is zero.
- R2: The processor has the lowest priority. At arbitration, any pending channel request wins over a pending processor request.
- R3: Among the channels, a lower index has higher priority (channel 0 over 1 over 2). Bit i of chan_req is channel i.
- R4: Only one memory cycle runs at a time. mem_req stays high until mem_ack. mem_req is low in the clock after mem_ack. A request that arrives during a cycle never preempts that cycle.
- R5: Address, direction and write data are latched when a cycle starts. Later changes on the owner's inputs do not alter mem_addr, mem_we or mem_wdata for that cycle. Slice i of a flattened channel bus is bits [i*W +: W].
- R6: Each cycle produces exactly one acknowledge, to the owning requester only. The acknowledge lasts one clock and comes in the clock after mem_ack.
- R7: On a read (select 0), the memory read data appears on the owner's read-data output when its acknowledge is high. Every other requester's read-data output keeps its value. A write (select 1) leaves all read-data outputs unchanged.
- R8: cpu_stall is high exactly when cpu_req is high and cpu_ack is low. Channel traffic alone never raises cpu_stall.
- R9: A write stores its latched data at its latched address. A later read of that address by any requester returns that data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | Processor direction, 1 = write |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ack | output | 1 | One-clock processor acknowledge |
| cpu_rdata | output | DATA_W | Processor read data |
| cpu_stall | output | 1 | Processor request pending and not yet acknowledged |
| chan_req | input | NUM_CHAN | Channel requests, bit i = channel i |
| chan_we | input | NUM_CHAN | Channel directions, 1 = write |
| chan_addr | input | NUM_CHAN*ADDR_W | Channel addresses, flattened |
| chan_wdata | input | NUM_CHAN*DATA_W | Channel write data, flattened |
| chan_ack | output | NUM_CHAN | One-clock channel acknowledges |
| chan_rdata | output | NUM_CHAN*DATA_W | Channel read data, flattened |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory direction, 1 = write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-clock memory completion |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The hardest situation to reach from the ports is a higher-priority request that arrives while a lower-priority cycle is already under way. The same applies to the owner changing its address and data in the middle of that cycle. The stimulus starts a lone processor write and waits until mem_req is seen high. It then moves the processor's address and data and raises channel 0 in the same clock. Reads of both addresses afterwards show which address was written and with what data, and the order of acknowledges shows that the cycle was not preempted. Every one of the fifteen non-empty request combinations is also raised in a single clock, for reads, then writes, then reads again. The bench predicts the service order and the memory contents from the priority rules.

// File: rtl/csm_pkg.sv
package csm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CYCLE  = 2'd1,
        ST_RETIRE = 2'd2
    } csm_state_e;
endpackage

// File: rtl/csm_arbiter.sv
module csm_arbiter #(
    parameter int unsigned NUM_REQ = 4,
    localparam int unsigned IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] req,
    output logic               any_req,
    output logic [IDX_W-1:0]   win_idx
);
    // lowest index wins; the processor sits at the top index
    always_comb begin
        any_req = |req;
        win_idx = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/csm_fsm.sv
module csm_fsm
    import csm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_req,
    input  logic       mem_ack,
    output logic       start,
    output logic       busy,
    output logic       retire,
    output csm_state_e state
);
    csm_state_e next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next;
        end
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:   if (any_req) next = ST_CYCLE;
            ST_CYCLE:  if (mem_ack) next = ST_RETIRE;
            ST_RETIRE: next = ST_IDLE;
            default:   next = ST_IDLE;
        endcase
    end

    always_comb begin
        start  = 1'b0;
        busy   = 1'b0;
        retire = 1'b0;
        unique case (state)
            ST_IDLE:   start  = any_req;
            ST_CYCLE:  busy   = 1'b1;
            ST_RETIRE: retire = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/csm_return.sv
module csm_return #(
    parameter int unsigned NUM_REQ = 4,
    parameter int unsigned DATA_W  = 24,
    localparam int unsigned IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture,
    input  logic                      retire,
    input  logic [IDX_W-1:0]          owner,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic [NUM_REQ-1:0]        ack,
    output logic [NUM_REQ*DATA_W-1:0] rdata
);
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_port
        logic mine;
        assign mine   = (owner == IDX_W'(g));
        assign ack[g] = retire & mine;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g*DATA_W +: DATA_W] <= '0;
            end else if (capture && mine) begin
                rdata[g*DATA_W +: DATA_W] <= mem_rdata;
            end
        end
    end
endmodule

// File: rtl/cyc_steal_mux.sv
module cyc_steal_mux
    import csm_pkg::*;
#(
    parameter int unsigned NUM_CHAN = 3,
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    output logic                       cpu_ack,
    output logic [DATA_W-1:0]          cpu_rdata,
    output logic                       cpu_stall,
    input  logic [NUM_CHAN-1:0]        chan_req,
    input  logic [NUM_CHAN-1:0]        chan_we,
    input  logic [NUM_CHAN*ADDR_W-1:0] chan_addr,
    input  logic [NUM_CHAN*DATA_W-1:0] chan_wdata,
    output logic [NUM_CHAN-1:0]        chan_ack,
    output logic [NUM_CHAN*DATA_W-1:0] chan_rdata,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic                       mem_ack,
    input  logic [DATA_W-1:0]          mem_rdata
);
    localparam int unsigned NUM_REQ = NUM_CHAN + 1;
    localparam int unsigned IDX_W   = $clog2(NUM_REQ);

    logic [NUM_REQ-1:0]        req_all;
    logic [NUM_REQ-1:0]        we_all;
    logic [ADDR_W-1:0]         addr_all  [NUM_REQ];
    logic [DATA_W-1:0]         wdata_all [NUM_REQ];
    logic                      any_req;
    logic [IDX_W-1:0]          win_idx;
    logic                      start;
    logic                      busy;
    logic                      retire;
    csm_state_e                state;
    logic [IDX_W-1:0]          owner_q;
    logic                      we_q;
    logic [ADDR_W-1:0]         addr_q;
    logic [DATA_W-1:0]         wdata_q;
    logic [NUM_REQ-1:0]        ack_all;
    logic [NUM_REQ*DATA_W-1:0] rdata_all;

    assign req_all = {cpu_req, chan_req};
    assign we_all  = {cpu_we, chan_we};

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        assign addr_all[g]  = chan_addr[g*ADDR_W +: ADDR_W];
        assign wdata_all[g] = chan_wdata[g*DATA_W +: DATA_W];
    end
    assign addr_all[NUM_CHAN]  = cpu_addr;
    assign wdata_all[NUM_CHAN] = cpu_wdata;

    csm_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .req     (req_all),
        .any_req (any_req),
        .win_idx (win_idx)
    );

    csm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_req (any_req),
        .mem_ack (mem_ack),
        .start   (start),
        .busy    (busy),
        .retire  (retire),
        .state   (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            owner_q <= win_idx;
            we_q    <= we_all[win_idx];
            addr_q  <= addr_all[win_idx];
            wdata_q <= wdata_all[win_idx];
        end
    end

    assign mem_req   = busy;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    csm_return #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (busy & mem_ack & ~we_q),
        .retire    (retire),
        .owner     (owner_q),
        .mem_rdata (mem_rdata),
        .ack       (ack_all),
        .rdata     (rdata_all)
    );

    assign chan_ack   = ack_all[NUM_CHAN-1:0];
    assign cpu_ack    = ack_all[NUM_CHAN];
    assign chan_rdata = rdata_all[NUM_CHAN*DATA_W-1:0];
    assign cpu_rdata  = rdata_all[NUM_REQ*DATA_W-1 -: DATA_W];
    assign cpu_stall  = cpu_req & ~cpu_ack;
endmodule

// File: rtl/csm_chk.sv
module csm_chk #(
    parameter int unsigned NUM_CHAN = 3,
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned IDX_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_req,
    input logic                cpu_ack,
    input logic                cpu_stall,
    input logic [NUM_CHAN-1:0] chan_req,
    input logic [NUM_CHAN-1:0] chan_ack,
    input logic                mem_req,
    input logic                mem_ack,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic [IDX_W-1:0]    owner
);
    logic [NUM_CHAN:0]   acks;
    logic [NUM_CHAN-1:0] above_mask;
    logic                owner_is_cpu;

    assign acks         = {cpu_ack, chan_ack};
    assign owner_is_cpu = (owner == IDX_W'(NUM_CHAN));

    always_comb begin
        for (int i = 0; i < NUM_CHAN; i++) begin
            above_mask[i] = (IDX_W'(i) < owner);
        end
    end

    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);

    // R4
    mem_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |=> !mem_req);

    // R5
    mem_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R6
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acks));

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|acks) |=> !(|acks));

    // R6
    ack_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|acks) |-> $past(mem_ack));

    // R8
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> cpu_req);

    // R8
    stall_clear_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !cpu_stall);

    // R2
    cpu_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && owner_is_cpu |-> ($past(chan_req) == '0));

    // R3
    chan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !owner_is_cpu |-> (($past(chan_req) & above_mask) == '0));
endmodule

bind cyc_steal_mux csm_chk #(
    .NUM_CHAN (NUM_CHAN),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ack   (cpu_ack),
    .cpu_stall (cpu_stall),
    .chan_req  (chan_req),
    .chan_ack  (chan_ack),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .owner     (owner_q)
);

// File: tb/sim_cyc_steal_mux.sv
module sim_cyc_steal_mux;
    localparam int NCH = 3;
    localparam int AW  = 15;
    localparam int DW  = 24;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [3:0]    rq   = '0;
    logic [3:0]    b_we = '0;
    logic [AW-1:0] b_addr [4];
    logic [DW-1:0] b_wd   [4];

    logic            cpu_ack, cpu_stall;
    logic [DW-1:0]   cpu_rdata;
    logic [NCH-1:0]  chan_ack;
    logic [NCH*DW-1:0] chan_rdata;
    logic            mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_ack;
    logic [DW-1:0]   mem_rdata;
    logic [3:0]      ack_v;

    assign ack_v = {cpu_ack, chan_ack};

    cyc_steal_mux #(.NUM_CHAN(NCH), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(rq[3]), .cpu_we(b_we[3]), .cpu_addr(b_addr[3]), .cpu_wdata(b_wd[3]),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .chan_req(rq[2:0]), .chan_we(b_we[2:0]),
        .chan_addr({b_addr[2], b_addr[1], b_addr[0]}),
        .chan_wdata({b_wd[2], b_wd[1], b_wd[0]}),
        .chan_ack(chan_ack), .chan_rdata(chan_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model with a fixed access latency
    logic [DW-1:0] mem    [64];
    logic [DW-1:0] shadow [64];
    int mcnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mem_req) begin
            if (mcnt == LAT - 1) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[5:0]];
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] get_rd(input int i);
        if (i == 3) return cpu_rdata;
        return chan_rdata[i*DW +: DW];
    endfunction

    task automatic run_mask(input logic [3:0] mask, input bit wr);
        int order [4];
        int n = 0;
        int pos = 0;
        int guard = 0;
        logic [DW-1:0] last [4];
        for (int i = 0; i < 4; i++) if (mask[i]) begin order[n] = i; n++; end
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            last[i] = get_rd(i);
            if (mask[i]) begin
                rq[i]     = 1'b1;
                b_we[i]   = wr;
                b_addr[i] = AW'({mask, 2'(i)});
                b_wd[i]   = {8'hA5, mask, 4'(i), 8'(int'(mask) * (i + 1) + 3)};
            end
        end
        while (pos < n && guard < 200) begin
            @(negedge clk);
            guard++;
            chk(cpu_stall == (rq[3] && !cpu_ack), "R8", 32'(cpu_stall), 32'(rq[3] && !cpu_ack));
            if (|ack_v) begin
                int k = 0;
                chk($onehot(ack_v), "R6", 32'(ack_v), 32'(1 << order[pos]));
                for (int i = 0; i < 4; i++) if (ack_v[i]) k = i;
                if (order[pos] == 3 || k == 3)
                    chk(k == order[pos], "R2", 32'(k), 32'(order[pos]));
                else
                    chk(k == order[pos], "R3", 32'(k), 32'(order[pos]));
                if (wr) begin
                    chk(get_rd(k) == last[k], "R7", 32'(get_rd(k)), 32'(last[k]));
                    shadow[b_addr[k][5:0]] = b_wd[k];
                end else begin
                    chk(get_rd(k) == shadow[b_addr[k][5:0]], "R9", 32'(get_rd(k)),
                        32'(shadow[b_addr[k][5:0]]));
                end
                for (int j = 0; j < 4; j++)
                    if (j != k) chk(get_rd(j) == last[j], "R7", 32'(get_rd(j)), 32'(last[j]));
                last[k] = get_rd(k);
                rq[k] = 1'b0;
                pos++;
            end
        end
        chk(pos == n, "R4", 32'(pos), 32'(n));
    endtask

    task automatic do_one(input int k, input bit wr, input logic [5:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd);
        int guard = 0;
        @(negedge clk);
        rq[k] = 1'b1; b_we[k] = wr; b_addr[k] = AW'(a); b_wd[k] = d;
        do begin
            @(negedge clk);
            guard++;
        end while (!ack_v[k] && guard < 100);
        chk(ack_v[k], "R6", 32'(ack_v), 32'(1 << k));
        rd = get_rd(k);
        rq[k] = 1'b0;
        if (wr) shadow[a] = d;
    endtask

    initial begin
        logic [DW-1:0] rd;
        int guard;
        int first_k;
        for (int a = 0; a < 64; a++) begin
            mem[a]    = DW'(a * 24'h1357 + 24'h0AB);
            shadow[a] = DW'(a * 24'h1357 + 24'h0AB);
        end
        for (int i = 0; i < 4; i++) begin b_addr[i] = '0; b_wd[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!mem_req && ack_v == 0 && !cpu_stall, "R1", {30'b0, mem_req, cpu_stall}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 after release, no requests
        chk(!mem_req && ack_v == 0 && !cpu_stall, "R1", {28'b0, ack_v}, 0);
        chk(cpu_rdata == 0 && chan_rdata == 0, "R1", 32'(cpu_rdata), 0);

        for (int m = 1; m < 16; m++) run_mask(4'(m), 1'b0);
        for (int m = 1; m < 16; m++) run_mask(4'(m), 1'b1);
        for (int m = 1; m < 16; m++) run_mask(4'(m), 1'b0);

        // mid-cycle arrival and owner input changes (R4, R5)
        @(negedge clk);
        rq[3] = 1'b1; b_we[3] = 1'b1; b_addr[3] = AW'(50); b_wd[3] = 24'hC0FFEE;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!mem_req && guard < 50);
        b_addr[3] = AW'(51); b_wd[3] = 24'h123456;
        rq[0] = 1'b1; b_we[0] = 1'b0; b_addr[0] = AW'(60);
        first_k = -1;
        guard = 0;
        while (rq != 0 && guard < 100) begin
            @(negedge clk);
            guard++;
            chk(cpu_stall == (rq[3] && !cpu_ack), "R8", 32'(cpu_stall), 32'(rq[3] && !cpu_ack));
            if (cpu_ack) begin
                if (first_k < 0) first_k = 3;
                rq[3] = 1'b0;
            end
            if (chan_ack[0]) begin
                if (first_k < 0) first_k = 0;
                chk(get_rd(0) == shadow[60], "R7", 32'(get_rd(0)), 32'(shadow[60]));
                rq[0] = 1'b0;
            end
        end
        chk(first_k == 3, "R4", 32'(first_k), 3);
        shadow[50] = 24'hC0FFEE;
        do_one(1, 1'b0, 6'd50, '0, rd);
        chk(rd == 24'hC0FFEE, "R5", 32'(rd), 32'h00C0FFEE);
        do_one(2, 1'b0, 6'd51, '0, rd);
        chk(rd == shadow[51], "R5", 32'(rd), 32'(shadow[51]));

        // channel-only traffic, processor idle: no stall (R8)
        do_one(2, 1'b1, 6'd7, 24'h0BEEF0, rd);
        chk(!cpu_stall, "R8", 32'(cpu_stall), 0);
        do_one(3, 1'b0, 6'd7, '0, rd);
        chk(rd == 24'h0BEEF0, "R9", 32'(rd), 32'h000BEEF0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule